// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps recently used virtual-to-physical page translations in a small table in which every entry is searched at once. A lookup gives a virtual address and an access kind (read or write). One cycle later the block returns a hit flag, a protection-fault flag, the entry's dirty state and the physical address. The physical address is the cached physical page number placed above the untranslated page-offset bits. On a miss the block reports it and does nothing more. The walker outside the block fetches the translation and sends it back through the refill channel.

Every entry holds a valid flag, a read permission, a write permission and a dirty flag. A permitted write marks its entry dirty. A lookup that hits but lacks the needed permission raises a fault and leaves the dirty and recency state untouched. Replacement is true least-recently-used. A refill fills an empty slot while one exists and otherwise evicts the entry that has gone longest without a permitted hit or a refill. A flush pulse empties the table in one cycle.

The lookup and refill channels are valid/ready. A transfer happens in a cycle where both valid and ready are high. Both ready signals are low only in a cycle where flush is high, and a request offered in that cycle must be held until ready returns. The result channel has no back-pressure: the consumer must take each result in the cycle it appears.

Top module: `tlb_fa`

## Requirements
- R1: An accepted lookup (lu_valid and lu_ready high at a clock edge) produces res_valid high for exactly the following cycle. In any other case res_valid is low, and while res_valid is low res_hit, res_fault and res_dirty are low. After reset res_valid is low.
- R2: On a hit, res_paddr equals the entry's physical page number in bits [PA_W-1:PAGE_BITS], with the request's bits [PAGE_BITS-1:0] copied unchanged below it.
- R3: On a miss, res_hit, res_fault, res_dirty and res_paddr are all zero.
- R4: A hit faults (res_fault=1, res_hit=1) when lu_write=0 and the entry lacks read permission, or when lu_write=1 and the entry lacks write permission.
- R5: res_dirty reports the entry's dirty flag as it was before the lookup. A permitted write sets the flag. A faulting write does not set it. A refill clears it.
- R6: While any entry is empty, a refill evicts no valid translation, so all ENTRIES distinct refills into an empty table stay resident.
- R7: When the table is full, a refill replaces the entry whose most recent permitted hit or refill is oldest. A faulting hit does not change the recency order.
- R8: A flush invalidates every entry in one cycle, so a lookup accepted after it misses until a new refill arrives.
- R9: When a lookup and a refill are accepted in the same cycle, the lookup sees the table as it was before the refill. The victim is chosen from the recency order as it was before that lookup. The refilled entry ends most recent, and the entry that hit ends second most recent.
- R10: lu_ready and fill_ready are low exactly in cycles with flush high. A request offered while ready is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every entry this cycle |
| lu_valid | input | 1 | Lookup request present |
| lu_ready | output | 1 | Lookup request can be taken |
| lu_write | input | 1 | Access kind: 0 read, 1 write |
| lu_vaddr | input | VA_W | Virtual address to translate |
| res_valid | output | 1 | Result of the lookup accepted last cycle |
| res_hit | output | 1 | Translation found |
| res_fault | output | 1 | Found but access not permitted |
| res_dirty | output | 1 | Dirty flag of the hit entry before this access |
| res_paddr | output | PA_W | Translated physical address, zero on a miss |
| fill_valid | input | 1 | Refill entry present |
| fill_ready | output | 1 | Refill entry can be taken |
| fill_vpn | input | VA_W-PAGE_BITS | Virtual page number of the refill |
| fill_ppn | input | PA_W-PAGE_BITS | Physical page number of the refill |
| fill_rd | input | 1 | Read permission of the refill |
| fill_wr | input | 1 | Write permission of the refill |

## Verification
A lookup and a refill can both be accepted in the same cycle. Then the refill's victim choice, the lookup's recency update and the lookup's dirty update all act on one state. The bench provokes this with a long run of cycles that carry both a lookup of a pooled page and a refill of a fresh page on a full table, which sometimes forces a write hit onto the very entry being evicted. It judges each result against a slot-and-timestamp model. In that model the lookup is resolved on the old contents and the victim is picked before the lookup's touch. The refill is then stamped after the hit, and all following hits and misses must agree.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;

  function automatic logic perm_ok(acc_e kind, logic can_rd, logic can_wr);
    return (kind == ACC_WRITE) ? can_wr : can_rd;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 32,
  parameter int TAG_W = 20,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [TAG_W-1:0] ent_tag [N],
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [IW-1:0]    hit_idx
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_tag[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IW'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N   = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  ent_valid,
  input  logic          a_en,
  input  logic [IW-1:0] a_idx,
  input  logic          b_en,
  input  logic [IW-1:0] b_idx,
  output logic [IW-1:0] victim
);
  // age 0 = most recent, N-1 = least recent; always a permutation
  logic [IW-1:0] age_q   [N];
  logic [IW-1:0] age_mid [N];
  logic [IW-1:0] age_nxt [N];
  logic [IW-1:0] free_idx, old_idx;
  logic          have_free;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      age_mid[i] = age_q[i];
      if (a_en) begin
        if (IW'(i) == a_idx)              age_mid[i] = '0;
        else if (age_q[i] < age_q[a_idx]) age_mid[i] = age_q[i] + 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      age_nxt[i] = age_mid[i];
      if (b_en) begin
        if (IW'(i) == b_idx)                  age_nxt[i] = '0;
        else if (age_mid[i] < age_mid[b_idx]) age_nxt[i] = age_mid[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else begin
      for (int i = 0; i < N; i++) age_q[i] <= age_nxt[i];
    end
  end

  always_comb begin
    free_idx  = '0;
    have_free = 1'b0;
    old_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_idx  = IW'(i);
        have_free = 1'b1;
      end
      if (age_q[i] == IW'(N - 1)) old_idx = IW'(i);
    end
  end

  assign victim = have_free ? free_idx : old_idx;
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int IW       = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lu_valid,
  output logic             lu_ready,
  input  logic             lu_write,
  input  logic [VA_W-1:0]  lu_vaddr,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_fault,
  output logic             res_dirty,
  output logic [PA_W-1:0]  res_paddr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_rd,
  input  logic             fill_wr
);
  logic [ENTRIES-1:0] ent_v, ent_r, ent_w, ent_d;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];

  logic          lu_acc, fill_acc, hit, allowed, touch_hit;
  logic [IW-1:0] hit_idx, victim;
  acc_e          kind;

  assign lu_ready   = !flush;
  assign fill_ready = !flush;
  assign lu_acc     = lu_valid && lu_ready;
  assign fill_acc   = fill_valid && fill_ready;
  assign kind       = acc_e'(lu_write);

  tlb_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_match (
    .ent_valid (ent_v),
    .ent_tag   (ent_vpn),
    .key       (lu_vaddr[VA_W-1:PAGE_BITS]),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  assign allowed   = perm_ok(kind, ent_r[hit_idx], ent_w[hit_idx]);
  assign touch_hit = lu_acc && hit && allowed;

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_valid (ent_v),
    .a_en      (touch_hit),
    .a_idx     (hit_idx),
    .b_en      (fill_acc),
    .b_idx     (victim),
    .victim    (victim)
  );

  // state flags: a refill to the same slot overrides a write-hit dirty set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      ent_d <= '0;
      ent_r <= '0;
      ent_w <= '0;
    end else if (flush) begin
      ent_v <= '0;
    end else begin
      if (touch_hit && kind == ACC_WRITE) ent_d[hit_idx] <= 1'b1;
      if (fill_acc) begin
        ent_v[victim] <= 1'b1;
        ent_d[victim] <= 1'b0;
        ent_r[victim] <= fill_rd;
        ent_w[victim] <= fill_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_acc) begin
      ent_vpn[victim] <= fill_vpn;
      ent_ppn[victim] <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_fault <= 1'b0;
      res_dirty <= 1'b0;
      res_paddr <= '0;
    end else begin
      res_valid <= lu_acc;
      res_hit   <= lu_acc && hit;
      res_fault <= lu_acc && hit && !allowed;
      res_dirty <= lu_acc && hit && ent_d[hit_idx];
      res_paddr <= (lu_acc && hit) ? {ent_ppn[hit_idx], lu_vaddr[PAGE_BITS-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            lu_valid,
  input logic            lu_ready,
  input logic [VA_W-1:0] lu_vaddr,
  input logic            res_valid,
  input logic            res_hit,
  input logic            res_fault,
  input logic            res_dirty,
  input logic [PA_W-1:0] res_paddr,
  input logic            fill_ready
);
  // R1
  accept_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_valid && lu_ready) |=> res_valid);
  // R1
  idle_gives_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lu_valid && lu_ready) |=> !res_valid);
  // R1
  quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_hit && !res_fault && !res_dirty));
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lu_valid && lu_ready) |=> (!res_hit || res_paddr[PAGE_BITS-1:0] == $past(lu_vaddr[PAGE_BITS-1:0])));
  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_paddr == '0 && !res_fault && !res_dirty));
  // R4
  fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> res_hit);
  // R8
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush ##1 (lu_valid && lu_ready) |=> !res_hit);
  // R10
  ready_low_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!lu_ready && !fill_ready));
  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (lu_ready && fill_ready));
endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)) u_chk (.*);

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;
  logic        clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic        lu_valid = 1'b0, lu_write = 1'b0;
  logic [31:0] lu_vaddr = '0;
  logic        lu_ready, res_valid, res_hit, res_fault, res_dirty;
  logic [31:0] res_paddr;
  logic        fill_valid = 1'b0, fill_ready, fill_rd = 1'b0, fill_wr = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  tlb_fa u_dut (.*);

  // page pool: index k maps to a distinct page and fixed permissions
  function automatic logic [19:0] kvpn(int k); return 20'(k * 40503 + 291); endfunction
  function automatic logic [19:0] kppn(int k); return 20'(k * 945 + 5);     endfunction
  function automatic bit kr(int k); return (k % 4) == 1 || (k % 4) == 3;    endfunction
  function automatic bit kw(int k); return (k % 4) >= 2;                    endfunction

  // reference: 32 slots with last-touch stamps
  bit     m_val [32];
  int     m_k   [32];
  bit     m_d   [32];
  longint m_st  [32];
  longint tick = 0;

  function automatic int find(int k);
    for (int s = 0; s < 32; s++) if (m_val[s] && m_k[s] == k) return s;
    return -1;
  endfunction

  function automatic int pick();
    int v = -1;
    for (int s = 0; s < 32; s++) if (!m_val[s]) return s;
    for (int s = 0; s < 32; s++) if (v < 0 || m_st[s] < m_st[v]) v = s;
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic step(bit lv, bit lw, int lk, int off, bit fv, int fk, bit fl, string tag);
    bit acc, facc, e_hit, ok, e_fault, e_d;
    logic [31:0] e_pa;
    int s, v;
    lu_valid = lv; lu_write = lw; lu_vaddr = {kvpn(lk), 12'(off)};
    fill_valid = fv; fill_vpn = kvpn(fk); fill_ppn = kppn(fk);
    fill_rd = kr(fk); fill_wr = kw(fk); flush = fl;
    acc  = lv && !fl;
    facc = fv && !fl;
    s = find(lk);
    e_hit   = acc && s >= 0;
    ok      = e_hit && (lw ? kw(lk) : kr(lk));
    e_fault = e_hit && !ok;
    e_d     = e_hit && m_d[s];
    e_pa    = e_hit ? {kppn(lk), 12'(off)} : 32'h0;
    v = pick();
    #1;
    chk(lu_ready == !fl, "R10", "lu_ready", 64'(lu_ready), 64'(!fl));
    chk(fill_ready == !fl, "R10", "fill_ready", 64'(fill_ready), 64'(!fl));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < 32; i++) m_val[i] = 0;
    end else begin
      if (ok) begin
        tick++; m_st[s] = tick;
        if (lw) m_d[s] = 1;
      end
      if (facc) begin
        tick++;
        m_val[v] = 1; m_k[v] = fk; m_d[v] = 0; m_st[v] = tick;
      end
    end
    @(negedge clk);
    lu_valid = 0; fill_valid = 0; flush = 0;
    chk(res_valid == acc, fl ? "R10" : "R1", "res_valid", 64'(res_valid), 64'(acc));
    if (acc) begin
      chk(res_hit == e_hit, tag, "res_hit", 64'(res_hit), 64'(e_hit));
      chk(res_fault == e_fault, "R4", "res_fault", 64'(res_fault), 64'(e_fault));
      chk(res_dirty == e_d, "R5", "res_dirty", 64'(res_dirty), 64'(e_d));
      chk(res_paddr == e_pa, e_hit ? "R2" : "R3", "res_paddr", 64'(res_paddr), 64'(e_pa));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R1 watchdog expired act=%h exp=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int nk;
    for (int i = 0; i < 32; i++) m_val[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(res_valid == 0, "R1", "reset res_valid", 64'(res_valid), 64'h0);
    rst_n = 1;
    step(1, 0, 5, 16'h10, 0, 0, 0, "R3");
    // fill empty table, then sweep: nothing evicted while room remains
    for (int i = 0; i < 32; i++) step(0, 0, 0, 0, 1, i, 0, "R6");
    for (int i = 0; i < 32; i++) step(1, 0, i, (i * 97) % 4096, 0, 0, 0, "R6");
    for (int i = 0; i < 32; i++) step(1, 1, i, (i * 131) % 4096, 0, 0, 0, "R4");
    for (int i = 0; i < 32; i++) step(1, 0, i, 4095 - i, 0, 0, 0, "R5");
    // mixed refills and lookups on a full table
    nk = 32;
    for (int n = 0; n < 160; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[2:0] == 3'd0) begin
        step(0, 0, 0, 0, 1, nk, 0, "R7");
        nk++;
      end else begin
        step(1, lf[3], int'(lf) % nk, int'(lf[11:0]), 0, 0, 0, "R7");
      end
    end
    // lookup and refill accepted together
    for (int n = 0; n < 100; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(1, lf[4], int'(lf) % nk, int'(lf[11:0]), 1, nk, 0, "R9");
      nk++;
    end
    // flush blocks both channels, then everything misses
    step(1, 0, 0, 0, 1, nk, 1, "R10");
    for (int k = 0; k < nk; k++) step(1, k[0], k, k % 4096, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 3, 0, "R8");
    step(1, 0, 3, 12'h2A5, 0, 0, 0, "R8");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule